// File: doc/BRIEF.md
# Scatter-Add Memory Engine

This block owns an on-chip word array and applies a stream of additive updates to it. Each request carries an index and an addend. The block reads the addressed word, adds the addend and writes the sum back. The requester never fetches the old value and never waits on a round trip. Requests may arrive one per clock, and several of them may name the same word while earlier updates to that word are still in the pipeline. The block guarantees that no contribution is lost.

A count mode replaces the addend with a programmable increment. A request then needs only an index, which suits histogram binning. Results are fetched through a separate synchronous read port. They are final once the idle flag shows that the pipeline is empty. A clear command zeroes the array one word per cycle. An index beyond the array is dropped and latches an error flag.

Top module: `scatter_add_unit`

## Requirements
- R1: Every accepted request whose index is below DEPTH adds its addend to the addressed word. The sum wraps modulo 2^DW, and the stored value is never replaced by the addend.
- R2: When `const_mode_i` is high at acceptance, the addend is the increment register and `req_add_i` is ignored. The increment register resets to INC_RST (default 1) and is loaded from `inc_data_i` on any cycle with `inc_wr_i` high. A load takes effect for requests accepted on later cycles.
- R3: Requests to the same index may be accepted on consecutive or nearby cycles. The final word equals the old value plus the sum of all their addends.
- R4: Outside a clear, `req_ready_o` is high on every cycle, so one request is accepted per cycle without stalls.
- R5: A request with an index of DEPTH or more is accepted but leaves every word unchanged. This includes the word its low bits alias. From the next cycle on, `err_o` is high and stays high until a clear.
- R6: Outside a clear, `idle_o` is low in the two cycles that follow the acceptance of an in-range request, and high otherwise.
- R7: `rd_data_o` shows the word at the `rd_idx_i` sampled on the previous edge. The value includes every update when `idle_o` was high during the cycle before that edge.
- R8: A pulse on `clear_i` drops `req_ready_o` and `idle_o` from the next cycle. The block lets earlier updates finish, then zeroes all DEPTH words at one per cycle and clears `err_o`. Only after that does `req_ready_o` return high.
- R9: After reset, `req_ready_o` and `idle_o` are high and `err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Update request valid |
| req_ready_o | output | 1 | Block accepts a request this cycle |
| req_idx_i | input | $clog2(DEPTH)+1 | Word index of the update |
| req_add_i | input | DW | Addend |
| const_mode_i | input | 1 | Use the increment register as addend |
| inc_wr_i | input | 1 | Load the increment register |
| inc_data_i | input | DW | New increment value |
| clear_i | input | 1 | Start zeroing the whole array |
| rd_idx_i | input | $clog2(DEPTH) | Result read address |
| rd_data_o | output | DW | Result read data, one cycle after the address |
| idle_o | output | 1 | No update in flight |
| err_o | output | 1 | Sticky out-of-range index flag |

## Verification
The bench targets the hazard of a request that reaches its read while the same word sits in the add stage, in the write stage, or was written on the very edge of the read. A design missing any of those forwarding paths would drop an addend in bursts to one index or in A/B/A alternation. Out-of-range indices such as DEPTH itself alias word 0 in their low bits, so a missing range check would corrupt that word. Sums that overflow must wrap. A clear issued together with a final request must still leave zeros, and a design that let the late write land after the wipe would show a stale word. Count mode is driven with junk on the addend input, so a design that ignored the mode would produce the wrong counts.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic [1:0] {
    CLR_RUN   = 2'd0,
    CLR_DRAIN = 2'd1,
    CLR_WIPE  = 2'd2
  } clr_state_e;
endpackage

// File: rtl/sa_mem.sv
module sa_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_a_idx_i,
  output logic [DW-1:0] rd_a_data_o,
  input  logic [AW-1:0] rd_b_idx_i,
  output logic [DW-1:0] rd_b_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i
);
  logic [DW-1:0] mem_q [DEPTH];

  // read-before-write on both ports
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_a_data_o <= '0;
      rd_b_data_o <= '0;
    end else begin
      rd_a_data_o <= mem_q[rd_a_idx_i];
      rd_b_data_o <= mem_q[rd_b_idx_i];
    end
  end
endmodule

// File: rtl/sa_fwd.sv
module sa_fwd #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0] s2_idx_i,
  input  logic [DW-1:0] mem_data_i,
  input  logic          s3_v_i,
  input  logic [AW-1:0] s3_idx_i,
  input  logic [DW-1:0] s3_sum_i,
  input  logic          s4_v_i,
  input  logic [AW-1:0] s4_idx_i,
  input  logic [DW-1:0] s4_sum_i,
  output logic [DW-1:0] operand_o
);
  // s4: written on the edge the read happened, missed by read-before-write
  // s3: not yet written; newest, so it wins
  always_comb begin
    operand_o = mem_data_i;
    if (s4_v_i && (s4_idx_i == s2_idx_i)) operand_o = s4_sum_i;
    if (s3_v_i && (s3_idx_i == s2_idx_i)) operand_o = s3_sum_i;
  end
endmodule

// File: rtl/sa_clear.sv
module sa_clear
  import sa_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          busy_i,
  output logic          run_o,
  output logic          wipe_o,
  output logic          wipe_start_o,
  output logic [AW-1:0] wipe_idx_o
);
  clr_state_e    state_q;
  logic [AW-1:0] cnt_q;

  assign run_o        = (state_q == CLR_RUN);
  assign wipe_o       = (state_q == CLR_WIPE);
  assign wipe_start_o = (state_q == CLR_DRAIN) && !busy_i;
  assign wipe_idx_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CLR_RUN;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        CLR_RUN:   if (clear_i) state_q <= CLR_DRAIN;
        CLR_DRAIN: if (!busy_i) begin
          state_q <= CLR_WIPE;
          cnt_q   <= '0;
        end
        CLR_WIPE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == AW'(DEPTH - 1)) state_q <= CLR_RUN;
        end
        default: state_q <= CLR_RUN;
      endcase
    end
  end

  AST_WIPE_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_o |-> !busy_i);  // R8
endmodule

// File: rtl/scatter_add_unit.sv
module scatter_add_unit #(
  parameter int          DW      = 32,
  parameter int          DEPTH   = 256,
  parameter logic [31:0] INC_RST = 32'd1,
  localparam int         AW      = $clog2(DEPTH),
  localparam int         IW      = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [IW-1:0] req_idx_i,
  input  logic [DW-1:0] req_add_i,
  input  logic          const_mode_i,
  input  logic          inc_wr_i,
  input  logic [DW-1:0] inc_data_i,
  input  logic          clear_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  output logic          idle_o,
  output logic          err_o
);
  logic          run, wipe, wipe_start;
  logic [AW-1:0] wipe_idx;
  logic          acc, in_rng, acc_ok;
  logic [DW-1:0] addend, inc_q;
  logic [DW-1:0] rdata, operand, sum2;
  logic          s2_v, s3_v, s4_v;
  logic [AW-1:0] s2_idx, s3_idx, s4_idx;
  logic [DW-1:0] s2_add, s3_sum, s4_sum;
  logic          wr_en;
  logic [AW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic          busy, err_q;

  assign req_ready_o = run;
  assign acc    = req_valid_i && req_ready_o;
  assign in_rng = req_idx_i < IW'(DEPTH);
  assign acc_ok = acc && in_rng;
  assign addend = const_mode_i ? inc_q : req_add_i;
  assign busy   = s2_v || s3_v;
  assign idle_o = run && !busy;
  assign err_o  = err_q;

  sa_clear #(.DEPTH(DEPTH)) u_clear (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .busy_i       (busy),
    .run_o        (run),
    .wipe_o       (wipe),
    .wipe_start_o (wipe_start),
    .wipe_idx_o   (wipe_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inc_q <= DW'(INC_RST);
    else if (inc_wr_i) inc_q <= inc_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (wipe_start) err_q <= 1'b0;
    else if (acc && !in_rng) err_q <= 1'b1;
  end

  // stage 1 -> 2: memory read issued on accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v <= 1'b0; s2_idx <= '0; s2_add <= '0;
    end else begin
      s2_v   <= acc_ok;
      s2_idx <= req_idx_i[AW-1:0];
      s2_add <= addend;
    end
  end

  sa_fwd #(.DW(DW), .DEPTH(DEPTH)) u_fwd (
    .s2_idx_i   (s2_idx),
    .mem_data_i (rdata),
    .s3_v_i     (s3_v),
    .s3_idx_i   (s3_idx),
    .s3_sum_i   (s3_sum),
    .s4_v_i     (s4_v),
    .s4_idx_i   (s4_idx),
    .s4_sum_i   (s4_sum),
    .operand_o  (operand)
  );

  assign sum2 = operand + s2_add;

  // stage 2 -> 3 (write) -> 4 (just-written shadow)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s3_v <= 1'b0; s3_idx <= '0; s3_sum <= '0;
      s4_v <= 1'b0; s4_idx <= '0; s4_sum <= '0;
    end else begin
      s3_v   <= s2_v;
      s3_idx <= s2_idx;
      s3_sum <= sum2;
      s4_v   <= s3_v;
      s4_idx <= s3_idx;
      s4_sum <= s3_sum;
    end
  end

  assign wr_en   = s3_v || wipe;
  assign wr_idx  = wipe ? wipe_idx : s3_idx;
  assign wr_data = wipe ? '0 : s3_sum;

  sa_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_a_idx_i  (req_idx_i[AW-1:0]),
    .rd_a_data_o (rdata),
    .rd_b_idx_i  (rd_idx_i),
    .rd_b_data_o (rd_data_o),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data)
  );

  AST_FWD_ACCUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s3_v && $past(s2_v && s3_v && (s2_idx == s3_idx))) |->
      (s3_sum == $past(s3_sum + s2_add)));  // R3
  AST_OOR_NO_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !in_rng) |=> !s2_v);  // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(wipe_start));  // R5
  AST_IDLE_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |=> !s3_v);  // R6
  AST_CLEAR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> !req_ready_o);  // R8
endmodule

// File: tb/tb_scatter_add_unit.sv
`timescale 1ns/1ps
module tb_scatter_add_unit;
  localparam int DW = 32, DEPTH = 256, AW = 8, IW = 9;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, const_mode = 0, inc_wr = 0, clear = 0;
  logic [IW-1:0] req_idx = '0;
  logic [DW-1:0] req_add = '0, inc_data = '0;
  logic [AW-1:0] rd_idx = '0;
  logic req_ready, idle, err;
  logic [DW-1:0] rd_data;

  scatter_add_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_idx_i(req_idx), .req_add_i(req_add), .const_mode_i(const_mode),
    .inc_wr_i(inc_wr), .inc_data_i(inc_data), .clear_i(clear), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .idle_o(idle), .err_o(err));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_inc = 1, exp_rd = 0;
  logic exp_err = 0, a1 = 0, a2 = 0, prev_idle = 0, rdy_s = 0;
  logic in_clear = 0, mem_init = 0, running = 0, done = 0;
  int skip = 0;

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // reference model, updated on accepting edges
  always @(posedge clk) if (rst_n) begin
    exp_rd = model[rd_idx];
    a2 = a1;
    a1 = 0;
    if (req_valid && rdy_s) begin
      if (req_idx >= IW'(DEPTH)) exp_err = 1;
      else begin
        model[req_idx[AW-1:0]] = model[req_idx[AW-1:0]] + (const_mode ? exp_inc : req_add);
        a1 = 1;
      end
    end
    if (inc_wr) exp_inc = inc_data;
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && running && !in_clear) begin
      chk(req_ready == 1'b1, "R4 ready", DW'(req_ready), 1);
      chk(err == exp_err, "R5 err", DW'(err), DW'(exp_err));
      chk(idle == !(a1 || a2), "R6 idle", DW'(idle), DW'(!(a1 || a2)));
      if (mem_init && prev_idle && skip == 0)
        chk(rd_data == exp_rd, "R7 R1 rd_data", rd_data, exp_rd);
      if (skip > 0) skip--;
      prev_idle = !(a1 || a2);
    end
    rdy_s = req_ready;
  end

  task automatic cyc(input int n);
    req_valid = 0; inc_wr = 0;
    repeat (n) begin @(posedge clk); #4; end
  endtask

  task automatic send(input int idx, input logic [DW-1:0] add, input logic cm);
    req_valid = 1; req_idx = IW'(idx); req_add = add; const_mode = cm;
    @(posedge clk); #4;
    req_valid = 0; const_mode = 0;
  endtask

  task automatic read_chk(input int idx, input logic [DW-1:0] expv, input string tag);
    cyc(3);
    rd_idx = AW'(idx);
    @(posedge clk); @(negedge clk);
    chk(rd_data == expv, tag, rd_data, expv);
    @(posedge clk); #4;
  endtask

  task automatic sweep(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      rd_idx = AW'(i);
      cyc(1);
    end
  endtask

  task automatic do_clear(input logic with_req);
    int n;
    in_clear = 1;
    clear = 1;
    if (with_req) begin req_valid = 1; req_idx = 9'd60; req_add = 32'd9; end
    @(posedge clk); #4;
    clear = 0; req_valid = 0;
    @(negedge clk);
    chk(!req_ready, "R8 ready low", DW'(req_ready), 0);
    chk(!idle, "R8 idle low", DW'(idle), 0);
    n = 0;
    while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    chk(n >= DEPTH - 1 && n < 2000, "R8 wipe length", DW'(n), DW'(DEPTH));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    exp_err = 0; a1 = 0; a2 = 0; prev_idle = 0;
    skip = 2; mem_init = 1;
    in_clear = 0;
    @(posedge clk); #4;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #4 rst_n = 1;
    @(negedge clk);
    chk(req_ready && idle && !err, "R9 reset state",
        {29'd0, req_ready, idle, err}, 32'b110);
    @(posedge clk); #4;
    running = 1;

    do_clear(0);
    sweep(0, DEPTH - 1);                      // R8 all zero

    for (int k = 1; k <= 6; k++) send(3, DW'(k), 0);   // R3 burst, one index
    read_chk(3, 32'd21, "R3 burst");

    send(10, 100, 0); send(11, 200, 0); send(10, 300, 0);
    send(11, 400, 0); send(10, 500, 0);       // R3 alternation
    read_chk(10, 32'd900, "R3 alt a");
    read_chk(11, 32'd600, "R3 alt b");

    for (int k = 0; k < 8; k++) send(40, 32'hdead, 1);  // R2 default inc
    read_chk(40, 32'd8, "R2 count default");
    inc_wr = 1; inc_data = 5;
    req_valid = 1; req_idx = 9'd41; req_add = 32'd77; const_mode = 1;
    @(posedge clk); #4;                       // same-cycle load uses old inc
    inc_wr = 0; req_valid = 0; const_mode = 0;
    send(41, 32'h1234, 1); send(41, 32'h1234, 1);
    read_chk(41, 32'd11, "R2 count after load");

    send(256, 7, 0); send(511, 9, 0);         // R5 out of range
    @(negedge clk);
    chk(err == 1'b1, "R5 err set", DW'(err), 1);
    @(posedge clk); #4;
    read_chk(0, 32'd0, "R5 alias word untouched");

    send(50, 32'hffff_ffff, 0); send(50, 3, 0);  // R1 wrap
    read_chk(50, 32'd2, "R1 wrap");
    send(51, 5, 0); cyc(1); send(51, 6, 0);
    read_chk(51, 32'd11, "R1 gap add");

    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 9) < 3) cyc(1);
      send($urandom_range(0, 15), DW'($urandom), $urandom_range(0, 4) == 0);
    end
    cyc(3);
    sweep(0, 15);

    send(60, 4, 0); send(60, 4, 0);
    do_clear(1);                              // R8 clear with late request
    read_chk(60, 32'd0, "R8 late write wiped");
    chk(err == 1'b0, "R8 err cleared", DW'(err), 0);
    send(60, 2, 0);
    read_chk(60, 32'd2, "R1 after clear");
    sweep(0, DEPTH - 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule